// File: doc/BRIEF.md
# Two-Common Multiplexed LCD Segment Driver

This block stores the on/off state of up to 56 display segments and turns it into drive codes for a liquid-crystal panel with two common electrodes. The panel runs at half duty with half bias. Each segment pin carries two segments, one for each common, so 28 segment pins cover the whole panel. Every pin output is a 2-bit level code. An analog bias network outside the block turns that code into a low, middle or high voltage.

A host writes segment data one digit at a time. A digit is four bits that cover two adjacent segment pins. The written data is staged and goes to the pins at the next phase boundary, so a waveform phase never changes halfway through. The frame timing comes from a divider on the reference clock. At the default settings, a 4.5 MHz clock gives a 100 Hz frame of four equal phases.

Three controls change how the pins are driven:
- A functional reset input blanks every segment and clears the stored data. The commons keep cycling while it is asserted.
- A backup input forces every pin low.
- A group select hands the last four segment pins to general-purpose output use. In that mode they take their values from either an input word or a latch word.

Top module: `lcd_duplex_drv`

## Requirements
- R1: Level codes are 00 low, 01 middle, 10 high, and 11 is never driven. `com_drv[1:0]` is common 1 and `com_drv[3:2]` is common 2. The phases repeat in this order: phase 0 (common 1 high, common 2 middle), phase 1 (common 1 low, common 2 middle), phase 2 (common 2 high, common 1 middle), phase 3 (common 2 low, common 1 middle).
- R2: Each phase lasts exactly REF_CLK_HZ/(FRAME_HZ*4) clock cycles. At the defaults (4.5 MHz, 100 Hz) that is 11250 cycles.
- R3: Pin k drives `seg_drv[2k+1:2k]`. In phases 0 and 1 its segment for common 1 applies, and in phases 2 and 3 its segment for common 2 applies. A segment that is on drives the opposite of the active common (high becomes low, low becomes high). A segment that is off drives the same level as the active common.
- R4: A write with digit d updates pins 2d and 2d+1. `wr_bits` bit 0 is pin 2d on common 1, bit 1 is pin 2d on common 2, bit 2 is pin 2d+1 on common 1, and bit 3 is pin 2d+1 on common 2. Digit values of SEG_PINS/2 and above (14 and 15 by default) change nothing.
- R5: Written data reaches the pins only at the next phase boundary. The rest of the current phase keeps showing the previous data.
- R6: After `rst_n` is released, the phase is 0 and every segment is off.
- R7: While `seg_clear` is high, every segment pin drives the off level and the commons keep their normal sequence and phase length. The stored segment data is cleared, so segments stay off after `seg_clear` falls until new data is written.
- R8: While `backup` is high, every common and segment pin drives 00. The stored data is kept and shows again once `backup` falls.
- R9: With `gp_enable` high and `seg_clear` low, pin SEG_PINS-4+j (pins 24..27 by default) drives 10 for a 1 and 00 for a 0 of bit j. The bit comes from `gp_in_word` when `gp_from_in` is 1 and from `gp_latch_word` when it is 0. All other pins keep their segment waveform.
- R10: `seg_clear` overrides `gp_enable`: while it is high, the four shared pins drive the segment-off level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seg_clear | input | 1 | Functional reset: blank and clear segments, commons keep running |
| backup | input | 1 | Forces every output pin low |
| wr_en | input | 1 | Digit write strobe |
| wr_digit | input | 4 | Digit index being written |
| wr_bits | input | 4 | Segment bits for the two pins of the digit |
| gp_enable | input | 1 | Hands the last four segment pins to general-purpose output |
| gp_from_in | input | 1 | 1: shared pins follow gp_in_word; 0: they follow gp_latch_word |
| gp_in_word | input | 4 | General-purpose source word A |
| gp_latch_word | input | 4 | General-purpose source word B |
| com_drv | output | 4 | Level codes of common 1 (bits 1:0) and common 2 (bits 3:2) |
| seg_drv | output | 56 | Level code of segment pin k in bits 2k+1:2k |

## Verification
The phase counter and the stored segment bits are the only state. A wrong phase value shows up on `com_drv` in the same cycle, either as a wrong pattern or as a phase of the wrong length. It is caught at the next phase boundary, within one phase time. A staging fault (data applied too early, lost, or written to the wrong pin) shows up on `seg_drv` either within the phase of the write or at the first check after the following boundary. A full four-phase frame covers both commons of every pin. Faults in the backup or general-purpose override change the pins at once, with no clock delay, so they are sampled a cycle after the control input changes.

// File: rtl/lcd2_pkg.sv
package lcd2_pkg;

  typedef logic [1:0] drv_t;

  localparam drv_t DRV_LOW  = 2'b00;
  localparam drv_t DRV_MID  = 2'b01;
  localparam drv_t DRV_HIGH = 2'b10;

  // Frame phases: which common is active and with which polarity
  typedef enum logic [1:0] {
    PH_C1_POS = 2'd0,
    PH_C1_NEG = 2'd1,
    PH_C2_POS = 2'd2,
    PH_C2_NEG = 2'd3
  } phase_e;

  function automatic drv_t invert_level(input drv_t lvl);
    return (lvl == DRV_HIGH) ? DRV_LOW : DRV_HIGH;
  endfunction

endpackage

// File: rtl/lcd2_timebase.sv
module lcd2_timebase
  import lcd2_pkg::*;
#(
  parameter int PHASE_CLKS = 11250
) (
  input  logic   clk,
  input  logic   rst_n,
  output logic   tick_o,
  output phase_e phase_o
);

  localparam int CNT_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_e           phase_q, phase_d;

  always_comb begin
    tick_o  = (cnt_q == CNT_LAST);
    cnt_d   = tick_o ? '0 : cnt_q + 1'b1;
    phase_d = tick_o ? phase_e'(phase_q + 2'd1) : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_C1_POS;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  // R2: the phase only moves on a divider terminal count
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(phase_q));

  // R1: every terminal count moves to a different phase
  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/lcd2_segmem.sv
module lcd2_segmem #(
  parameter int SEG_PINS = 28,
  parameter int DIG_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                wr_en_i,
  input  logic [DIG_W-1:0]    wr_digit_i,
  input  logic [3:0]          wr_bits_i,
  input  logic                load_i,
  output logic [SEG_PINS-1:0] on_c1_o,
  output logic [SEG_PINS-1:0] on_c2_o
);

  // Staging copy (written by host) and shown copy (loaded at phase edge)
  logic [SEG_PINS-1:0] stg1_q, stg1_d, stg2_q, stg2_d;
  logic [SEG_PINS-1:0] shw1_q, shw1_d, shw2_q, shw2_d;

  for (genvar p = 0; p < SEG_PINS; p++) begin : g_pin
    localparam int DIG  = p / 2;
    localparam int HALF = p % 2;
    logic hit;
    assign hit       = wr_en_i && (wr_digit_i == DIG_W'(DIG));
    assign stg1_d[p] = clr_i ? 1'b0 : (hit ? wr_bits_i[2*HALF]     : stg1_q[p]);
    assign stg2_d[p] = clr_i ? 1'b0 : (hit ? wr_bits_i[2*HALF + 1] : stg2_q[p]);
  end

  always_comb begin
    shw1_d = shw1_q;
    shw2_d = shw2_q;
    if (clr_i) begin
      shw1_d = '0;
      shw2_d = '0;
    end else if (load_i) begin
      shw1_d = stg1_d;
      shw2_d = stg2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
      shw1_q <= '0;
      shw2_q <= '0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
      shw1_q <= shw1_d;
      shw2_q <= shw2_d;
    end
  end

  assign on_c1_o = shw1_q;
  assign on_c2_o = shw2_q;

  // R5: shown data changes only at a phase edge or on a clear
  p_shown_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clr_i) |=> ($stable(shw1_q) && $stable(shw2_q)));

  // R7: a clear empties both copies
  p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (shw1_q == '0 && shw2_q == '0 && stg1_q == '0 && stg2_q == '0));

endmodule

// File: rtl/lcd2_wave.sv
module lcd2_wave
  import lcd2_pkg::*;
#(
  parameter int SEG_PINS = 28
) (
  input  phase_e                phase_i,
  input  logic                  blank_i,
  input  logic [SEG_PINS-1:0]   on_c1_i,
  input  logic [SEG_PINS-1:0]   on_c2_i,
  output drv_t                  com1_o,
  output drv_t                  com2_o,
  output logic [2*SEG_PINS-1:0] seg_o
);

  logic act_c1;
  drv_t act_lvl, opp_lvl;

  always_comb begin
    act_c1  = (phase_i == PH_C1_POS) || (phase_i == PH_C1_NEG);
    act_lvl = ((phase_i == PH_C1_POS) || (phase_i == PH_C2_POS)) ? DRV_HIGH : DRV_LOW;
    opp_lvl = invert_level(act_lvl);
    com1_o  = act_c1 ? act_lvl : DRV_MID;
    com2_o  = act_c1 ? DRV_MID : act_lvl;
  end

  for (genvar p = 0; p < SEG_PINS; p++) begin : g_seg
    logic lit;
    assign lit            = !blank_i && (act_c1 ? on_c1_i[p] : on_c2_i[p]);
    assign seg_o[2*p +: 2] = lit ? opp_lvl : act_lvl;
  end

endmodule

// File: rtl/lcd2_outmux.sv
module lcd2_outmux
  import lcd2_pkg::*;
#(
  parameter int SEG_PINS = 28,
  parameter int GP_PINS  = 4
) (
  input  logic                  backup_i,
  input  logic                  gp_on_i,
  input  logic                  gp_from_in_i,
  input  logic [GP_PINS-1:0]    gp_in_i,
  input  logic [GP_PINS-1:0]    gp_latch_i,
  input  drv_t                  com1_i,
  input  drv_t                  com2_i,
  input  logic [2*SEG_PINS-1:0] seg_i,
  output logic [3:0]            com_o,
  output logic [2*SEG_PINS-1:0] seg_o
);

  localparam int GP_BASE = SEG_PINS - GP_PINS;

  logic [GP_PINS-1:0] gp_word;
  assign gp_word = gp_from_in_i ? gp_in_i : gp_latch_i;
  assign com_o   = backup_i ? 4'b0000 : {com2_i, com1_i};

  for (genvar p = 0; p < SEG_PINS; p++) begin : g_out
    if (p >= GP_BASE) begin : g_shared
      drv_t gp_lvl;
      assign gp_lvl = gp_word[p - GP_BASE] ? DRV_HIGH : DRV_LOW;
      assign seg_o[2*p +: 2] = backup_i ? DRV_LOW :
                               (gp_on_i ? gp_lvl : seg_i[2*p +: 2]);
    end else begin : g_lcd
      assign seg_o[2*p +: 2] = backup_i ? DRV_LOW : seg_i[2*p +: 2];
    end
  end

endmodule

// File: rtl/lcd_duplex_drv.sv
module lcd_duplex_drv
  import lcd2_pkg::*;
#(
  parameter int REF_CLK_HZ = 4_500_000,
  parameter int FRAME_HZ   = 100,
  parameter int SEG_PINS   = 28,
  parameter int GP_PINS    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seg_clear,
  input  logic                  backup,
  input  logic                  wr_en,
  input  logic [3:0]            wr_digit,
  input  logic [3:0]            wr_bits,
  input  logic                  gp_enable,
  input  logic                  gp_from_in,
  input  logic [GP_PINS-1:0]    gp_in_word,
  input  logic [GP_PINS-1:0]    gp_latch_word,
  output logic [3:0]            com_drv,
  output logic [2*SEG_PINS-1:0] seg_drv
);

  localparam int PHASES     = 4;
  localparam int PHASE_CLKS = REF_CLK_HZ / (FRAME_HZ * PHASES);

  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                tick;
  phase_e              phase;
  logic [SEG_PINS-1:0] on_c1, on_c2;
  drv_t                com1_lvl, com2_lvl;
  logic [2*SEG_PINS-1:0] seg_lcd;
  logic                gp_on;

  assign gp_on = gp_enable && !seg_clear;

  lcd2_timebase #(.PHASE_CLKS(PHASE_CLKS)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_o  (tick),
    .phase_o (phase)
  );

  lcd2_segmem #(.SEG_PINS(SEG_PINS), .DIG_W(4)) u_segmem (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (seg_clear),
    .wr_en_i    (wr_en),
    .wr_digit_i (wr_digit),
    .wr_bits_i  (wr_bits),
    .load_i     (tick),
    .on_c1_o    (on_c1),
    .on_c2_o    (on_c2)
  );

  lcd2_wave #(.SEG_PINS(SEG_PINS)) u_wave (
    .phase_i (phase),
    .blank_i (seg_clear),
    .on_c1_i (on_c1),
    .on_c2_i (on_c2),
    .com1_o  (com1_lvl),
    .com2_o  (com2_lvl),
    .seg_o   (seg_lcd)
  );

  lcd2_outmux #(.SEG_PINS(SEG_PINS), .GP_PINS(GP_PINS)) u_outmux (
    .backup_i     (backup),
    .gp_on_i      (gp_on),
    .gp_from_in_i (gp_from_in),
    .gp_in_i      (gp_in_word),
    .gp_latch_i   (gp_latch_word),
    .com1_i       (com1_lvl),
    .com2_i       (com2_lvl),
    .seg_i        (seg_lcd),
    .com_o        (com_drv),
    .seg_o        (seg_drv)
  );

  // Checker view of the pins
  drv_t chk_active;
  assign chk_active = (com_drv[1:0] == DRV_MID) ? com_drv[3:2] : com_drv[1:0];

  // R8: backup holds every pin low
  p_backup_low_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    backup |-> (com_drv == 4'b0000 && seg_drv == '0));

  // R1: exactly one common sits at the middle level
  p_one_common_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !backup |-> ((com_drv[1:0] == DRV_MID) != (com_drv[3:2] == DRV_MID)));

  // R7 / R10: while cleared, every segment pin follows the active common
  p_clear_blank_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seg_clear && !backup) |-> (seg_drv == {SEG_PINS{chk_active}}));

endmodule

// File: tb/lcd_duplex_drv_test.sv
`timescale 1ns/1ps
module lcd_duplex_drv_test;

  localparam int NPIN = 28;
  localparam int PH_LEN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seg_clear = 1'b0, backup = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_digit = '0, wr_bits = '0;
  logic gp_enable = 1'b0, gp_from_in = 1'b0;
  logic [3:0] gp_in_word = '0, gp_latch_word = '0;
  logic [3:0] com_drv;
  logic [2*NPIN-1:0] seg_drv;

  int n_chk = 0, n_bad = 0;
  logic [NPIN-1:0] m1 = '0, m2 = '0;   // bench model of shown segment data

  always #5 clk = ~clk;

  lcd_duplex_drv #(.REF_CLK_HZ(3200), .FRAME_HZ(100)) uut (
    .clk(clk), .rst_n(rst_n), .seg_clear(seg_clear), .backup(backup),
    .wr_en(wr_en), .wr_digit(wr_digit), .wr_bits(wr_bits),
    .gp_enable(gp_enable), .gp_from_in(gp_from_in),
    .gp_in_word(gp_in_word), .gp_latch_word(gp_latch_word),
    .com_drv(com_drv), .seg_drv(seg_drv));

  function automatic logic [3:0] com_pat(input int p);
    case (p)
      0: return 4'b0110;
      1: return 4'b0100;
      2: return 4'b1001;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [2*NPIN-1:0] exp_seg(input int p);
    logic [2*NPIN-1:0] v;
    logic [1:0] act, opp;
    act = (p == 0 || p == 2) ? 2'b10 : 2'b00;
    opp = (act == 2'b10) ? 2'b00 : 2'b10;
    for (int k = 0; k < NPIN; k++) begin
      logic on;
      on = (p < 2) ? m1[k] : m2[k];
      v[2*k +: 2] = (on && !seg_clear) ? opp : act;
      if (k >= NPIN - 4 && gp_enable && !seg_clear)
        v[2*k +: 2] = (gp_from_in ? gp_in_word[k-(NPIN-4)] : gp_latch_word[k-(NPIN-4)]) ? 2'b10 : 2'b00;
      if (backup) v[2*k +: 2] = 2'b00;
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Wait for the first negedge of phase p, judged from the commons
  task automatic sync_phase(input int p);
    logic [3:0] prev;
    prev = com_drv;
    forever begin
      @(negedge clk);
      if (com_drv == com_pat(p) && prev != com_pat(p)) break;
      prev = com_drv;
    end
  endtask

  task automatic check_frame(input string tag);
    for (int p = 0; p < 4; p++) begin
      sync_phase(p);
      chk({tag, " com"}, 64'(com_drv), 64'(com_pat(p)));
      chk({tag, " seg"}, 64'(seg_drv), 64'(exp_seg(p)));
    end
  endtask

  task automatic write_digit(input int d, input logic [3:0] b);
    wr_en = 1'b1; wr_digit = 4'(d); wr_bits = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (d < NPIN/2) begin
      m1[2*d] = b[0]; m2[2*d] = b[1]; m1[2*d+1] = b[2]; m2[2*d+1] = b[3];
    end
  endtask

  task automatic t_reset_state();
    // R6: during and after reset phase 0, all segments off
    chk("R6 reset com", 64'(com_drv), 64'(com_pat(0)));
    chk("R6 reset seg", 64'(seg_drv), 64'(exp_seg(0)));
  endtask

  task automatic t_sequence();
    logic [3:0] pat;
    int n;
    sync_phase(0);
    for (int i = 0; i < 8; i++) begin
      pat = com_drv; n = 0;
      while (com_drv == pat && n < 100) begin @(negedge clk); n++; end
      chk("R2 phase length", 64'(n), 64'(PH_LEN));
      chk("R1 phase order", 64'(com_drv), 64'(com_pat((i + 1) % 4)));
    end
  endtask

  task automatic t_patterns();
    @(negedge clk);
    for (int d = 0; d < NPIN/2; d++) write_digit(d, 4'((d * 5 + 3) & 15));
    check_frame("R3 R4 pattern A");
    for (int d = 0; d < NPIN/2; d += 2) write_digit(d, 4'((d * 7 + 9) & 15) ^ 4'hF);
    check_frame("R3 R4 pattern B");
  endtask

  task automatic t_ignore_digits();
    @(negedge clk);
    write_digit(14, 4'hF);
    write_digit(15, 4'hA);
    check_frame("R4 out-of-range digit ignored");
  endtask

  task automatic t_staging();
    logic [2*NPIN-1:0] old_v;
    sync_phase(0);
    old_v = exp_seg(0);
    write_digit(3, ~((m2[7] << 3) | (m1[7] << 2) | (m2[6] << 1) | m1[6]));
    chk("R5 no change mid-phase", 64'(seg_drv), 64'(old_v));
    repeat (3) @(negedge clk);
    chk("R5 still old late in phase", 64'(seg_drv), 64'(old_v));
    sync_phase(1);
    chk("R5 new data at boundary", 64'(seg_drv), 64'(exp_seg(1)));
  endtask

  task automatic t_backup();
    sync_phase(2);
    backup = 1'b1; gp_enable = 1'b1; gp_from_in = 1'b1; gp_in_word = 4'hF;
    for (int i = 0; i < 3; i++) begin
      repeat (5) @(negedge clk);
      chk("R8 backup com low", 64'(com_drv), 64'h0);
      chk("R8 backup seg low", 64'(seg_drv), 64'h0);
    end
    backup = 1'b0; gp_enable = 1'b0;
    check_frame("R8 data kept after backup");
  endtask

  task automatic t_gp();
    gp_enable = 1'b1; gp_from_in = 1'b1;
    gp_in_word = 4'b1010; gp_latch_word = 4'b0110;
    check_frame("R9 gp from input word");
    gp_from_in = 1'b0;
    check_frame("R9 gp from latch word");
    gp_enable = 1'b0;
  endtask

  task automatic t_clear();
    int n;
    sync_phase(1);
    seg_clear = 1'b1;
    @(negedge clk);
    m1 = '0; m2 = '0;
    chk("R7 blank immediately", 64'(seg_drv), 64'(exp_seg(1)));
    check_frame("R7 clear commons run");
    sync_phase(2);
    n = 0;
    while (com_drv == com_pat(2) && n < 100) begin @(negedge clk); n++; end
    chk("R7 phase length in clear", 64'(n), 64'(PH_LEN));
    seg_clear = 1'b0;
    check_frame("R7 data cleared");
  endtask

  task automatic t_clear_over_gp();
    @(negedge clk);
    write_digit(12, 4'hF);
    write_digit(13, 4'hF);
    gp_enable = 1'b1; gp_from_in = 1'b1; gp_in_word = 4'b0101;
    seg_clear = 1'b1;
    @(negedge clk);
    m1 = '0; m2 = '0;
    check_frame("R10 clear overrides gp");
    seg_clear = 1'b0; gp_enable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_sequence();
    check_frame("R6 all off after reset");
    t_patterns();
    t_ignore_digits();
    t_staging();
    t_backup();
    t_gp();
    t_clear();
    t_clear_over_gp();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule